// File: doc/BRIEF.md
# Two-Stage Serial Clock Prescaler

This block turns the functional clock into the timing strobes for a synchronous serial shift engine. Two dividers are cascaded. The first is a coarse divider shared by every device on the bus. It picks one of four ratios, including the uneven ratios 7 and 10. The second is a fine divider picked for the device that is currently selected. It divides by 2, 4 or 8. The serial clock period is the product of the two ratios, so the slowest setting is 80 functional clocks per bit.

Three outputs are provided. The first is a one-cycle strobe from the coarse stage. The second is a one-cycle edge strobe at twice the serial clock rate, which the shift engine uses to launch and capture data. The third is a serial clock level that toggles on every edge strobe. A single enable input gates the whole chain. While the enable is low, the block stays quiet and reloads itself from the current settings, so the next start begins on a full count.

A ratio written while the chain is running is never applied in the middle of a count. A new coarse ratio is taken when the coarse counter wraps. A new fine code is taken when the fine counter wraps. No output interval is ever shorter than both the old and the new setting.

Top module: `sclk_prescaler`

## Requirements
- R1: Coarse ratio select `coarse_sel_i` decodes as 0 = divide by 2, 1 = divide by 4, 2 = divide by 7, 3 = divide by 10. While running, `coarse_tick_o` pulses for one cycle exactly once every that many clocks, evenly spaced.
- R2: Fine code `fine_code_i` decodes as 00 = divide by 2, 01 = divide by 4, 10 = divide by 8. `edge_tick_o` pulses once every coarse ratio × fine ratio / 2 clocks.
- R3: Fine code 11 behaves exactly like code 10 (divide by 8).
- R4: `sclk_o` rises only in the cycle after an `edge_tick_o` pulse and toggles once per edge tick. Its high time and low time are therefore equal, and its period is coarse ratio × fine ratio clocks.
- R5: Once `enable_i` has been sampled low at a clock edge, `coarse_tick_o` and `edge_tick_o` stay low from the next cycle on. `sclk_o` is low from two cycles after the enable is sampled low.
- R6: If `enable_i` is first sampled high at a clock edge, the first `coarse_tick_o` is visible after the coarse ratio edges have elapsed, counting that edge. The first `edge_tick_o` is visible after coarse ratio × fine ratio / 2 edges.
- R7: A change of `coarse_sel_i` while running takes effect only when the coarse counter wraps. The interval in progress finishes at the old ratio.
- R8: A change of `fine_code_i` while running takes effect only when the fine counter wraps. The edge interval in progress finishes at the old ratio.
- R9: `edge_tick_o` is high only in cycles where `coarse_tick_o` is also high.
- R10: While `rst` is high, and in the cycle after it falls, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous reset, active high |
| enable_i | input | 1 | Runs the prescaler when high |
| coarse_sel_i | input | 2 | Shared coarse ratio select (2/4/7/10) |
| fine_code_i | input | 2 | Fine ratio code of the selected device (2/4/8/8) |
| coarse_tick_o | output | 1 | One-cycle strobe at the coarse rate |
| edge_tick_o | output | 1 | One-cycle strobe at twice the serial clock rate |
| sclk_o | output | 1 | Serial clock level, toggles on each edge tick |

## Verification
The bench sweeps all sixteen combinations of coarse select and fine code. For each one it measures the start latency, the coarse spacing, the edge spacing and the alternation of the serial clock. A decoder that mapped the uneven ratio wrongly, or that treated code 11 as divide by 1 or 2, would show the wrong interval at once. The bench changes the coarse select and the fine code one cycle after a wrap. A design that reloaded immediately would end the current interval early and produce a short serial clock phase, while a correct one shows the old interval and then the new one. After each run the bench drops the enable and watches for stray strobes or a serial clock left high.

// File: rtl/sclk_prescaler_pkg.sv
package sclk_prescaler_pkg;

    // Largest coarse ratio and largest fine half-ratio set the counter widths.
    localparam int COARSE_MAX   = 10;
    localparam int FINE_HALFMAX = 4;
    localparam int COARSE_CW    = $clog2(COARSE_MAX);
    localparam int FINE_CW      = $clog2(FINE_HALFMAX);
    localparam int SEL_W        = 2;

    typedef enum logic [SEL_W-1:0] {
        COARSE_DIV2  = 2'd0,
        COARSE_DIV4  = 2'd1,
        COARSE_DIV7  = 2'd2,
        COARSE_DIV10 = 2'd3
    } coarse_sel_e;

    typedef enum logic [SEL_W-1:0] {
        FINE_DIV2    = 2'd0,
        FINE_DIV4    = 2'd1,
        FINE_DIV8    = 2'd2,
        FINE_DIV8ALT = 2'd3
    } fine_code_e;

    // Settings as presented to the counters.
    typedef struct packed {
        coarse_sel_e coarse;
        fine_code_e  fine;
    } presc_cfg_t;

    // Reload value of the coarse counter: ratio minus one.
    function automatic logic [COARSE_CW-1:0] coarse_reload(coarse_sel_e sel);
        case (sel)
            COARSE_DIV2:  return COARSE_CW'(1);
            COARSE_DIV4:  return COARSE_CW'(3);
            COARSE_DIV7:  return COARSE_CW'(6);
            default:      return COARSE_CW'(9);
        endcase
    endfunction

    // Reload value of the fine counter: half of the fine ratio, minus one.
    function automatic logic [FINE_CW-1:0] fine_reload(fine_code_e code);
        case (code)
            FINE_DIV2:    return FINE_CW'(0);
            FINE_DIV4:    return FINE_CW'(1);
            default:      return FINE_CW'(3);
        endcase
    endfunction

endpackage

// File: rtl/sclk_presc_coarse.sv
module sclk_presc_coarse #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] reload_val,
    output logic          tick
);
    logic [CW-1:0] cnt_q;

    // Reload is sampled only at the wrap, so a new ratio never cuts a count short.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= reload_val;
        end else if (cnt_q == '0) begin
            cnt_q <= reload_val;
        end else begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/sclk_presc_fine.sv
module sclk_presc_fine #(
    parameter int FW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          coarse_tick,
    input  logic [FW-1:0] reload_val,
    output logic          edge_tick,
    output logic          sclk
);
    logic [FW-1:0] cnt_q;
    logic          sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= reload_val;
            sclk_q <= 1'b0;
        end else if (coarse_tick) begin
            if (cnt_q == '0) begin
                cnt_q  <= reload_val;
                sclk_q <= ~sclk_q;
            end else begin
                cnt_q  <= cnt_q - FW'(1);
            end
        end
    end

    assign edge_tick = coarse_tick && (cnt_q == '0);
    assign sclk      = sclk_q;
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
    import sclk_prescaler_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable_i,
    input  logic [1:0] coarse_sel_i,
    input  logic [1:0] fine_code_i,
    output logic       coarse_tick_o,
    output logic       edge_tick_o,
    output logic       sclk_o
);
    presc_cfg_t             cfg;
    logic                   run_q;
    logic [COARSE_CW-1:0]   coarse_rl;
    logic [FINE_CW-1:0]     fine_rl;
    logic                   c_tick;

    assign cfg.coarse = coarse_sel_e'(coarse_sel_i);
    assign cfg.fine   = fine_code_e'(fine_code_i);
    assign coarse_rl  = coarse_reload(cfg.coarse);
    assign fine_rl    = fine_reload(cfg.fine);

    // Registered enable: the counters start from a freshly loaded state.
    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= enable_i;
    end

    sclk_presc_coarse #(.CW(COARSE_CW)) u_coarse (
        .clk        (clk),
        .rst        (rst),
        .run        (run_q),
        .reload_val (coarse_rl),
        .tick       (c_tick)
    );

    sclk_presc_fine #(.FW(FINE_CW)) u_fine (
        .clk         (clk),
        .rst         (rst),
        .run         (run_q),
        .coarse_tick (c_tick),
        .reload_val  (fine_rl),
        .edge_tick   (edge_tick_o),
        .sclk        (sclk_o)
    );

    assign coarse_tick_o = c_tick;
endmodule

// File: rtl/sclk_prescaler_checker.sv
module sclk_prescaler_checker (
    input logic clk,
    input logic rst,
    input logic enable_i,
    input logic coarse_tick_o,
    input logic edge_tick_o,
    input logic sclk_o
);
    logic [3:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || coarse_tick_o || !enable_i) gap_q <= '0;
        else if (gap_q != 4'hF)                gap_q <= gap_q + 4'd1;
    end

    // R9
    a_r9_edge_on_coarse: assert property (@(posedge clk) disable iff (rst)
        edge_tick_o |-> coarse_tick_o);

    // R1: the smallest ratio is 2, so two strobes are never adjacent
    a_r1_coarse_min_gap: assert property (@(posedge clk) disable iff (rst)
        coarse_tick_o |=> !coarse_tick_o);

    // R1: the largest ratio is 10
    a_r1_coarse_max_gap: assert property (@(posedge clk) disable iff (rst)
        gap_q <= 4'd10);

    // R5
    a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !$past(enable_i) |-> (!coarse_tick_o && !edge_tick_o));

    // R5
    a_r5_sclk_low_off: assert property (@(posedge clk) disable iff (rst)
        (!$past(enable_i) && !$past(enable_i, 2)) |-> !sclk_o);

    // R4
    a_r4_sclk_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> $past(edge_tick_o));

    // R10
    a_r10_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sclk_o && !coarse_tick_o && !edge_tick_o));
endmodule

bind sclk_prescaler sclk_prescaler_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable_i      (enable_i),
    .coarse_tick_o (coarse_tick_o),
    .edge_tick_o   (edge_tick_o),
    .sclk_o        (sclk_o)
);

// File: tb/sclk_prescaler_test.sv
module sclk_prescaler_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable_i = 1'b0;
    logic [1:0] coarse_sel_i = 2'd0;
    logic [1:0] fine_code_i = 2'd0;
    logic       coarse_tick_o, edge_tick_o, sclk_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    sclk_prescaler uut (
        .clk           (clk),
        .rst           (rst),
        .enable_i      (enable_i),
        .coarse_sel_i  (coarse_sel_i),
        .fine_code_i   (fine_code_i),
        .coarse_tick_o (coarse_tick_o),
        .edge_tick_o   (edge_tick_o),
        .sclk_o        (sclk_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int coarse_ratio(int s);
        case (s)
            0: return 2;
            1: return 4;
            2: return 7;
            default: return 10;
        endcase
    endfunction

    function automatic int fine_ratio(int c);
        case (c)
            0: return 2;
            1: return 4;
            default: return 8;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling edges until one shows a coarse strobe.
    task automatic wait_coarse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!coarse_tick_o && n < 1000);
    endtask

    task automatic wait_edge(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!edge_tick_o && n < 1000);
    endtask

    task automatic stop_and_check_quiet();
        int bad;
        enable_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (coarse_tick_o || edge_tick_o || sclk_o) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R5 quiet after disable", bad, 0);
    endtask

    initial begin
        int n;
        int r1;
        int half;
        logic prev_sclk;
        string req;

        // R10: reset state
        repeat (3) @(negedge clk);
        check(!coarse_tick_o && !edge_tick_o && !sclk_o, "R10 outputs in reset",
              {coarse_tick_o, edge_tick_o, sclk_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!coarse_tick_o && !edge_tick_o && !sclk_o, "R10 outputs after reset",
              {coarse_tick_o, edge_tick_o, sclk_o}, 0);

        // Sweep every setting combination
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                r1   = coarse_ratio(s);
                half = r1 * fine_ratio(c) / 2;
                req  = (c == 3) ? "R3" : "R2";
                coarse_sel_i = 2'(s);
                fine_code_i  = 2'(c);
                enable_i     = 1'b1;
                wait_edge(n);
                check(n == half, "R6 first edge latency", n, half);
                for (int k = 0; k < 4; k++) begin
                    wait_coarse(n);
                    check(n == r1, "R1 coarse spacing", n, r1);
                end
                wait_edge(n);
                prev_sclk = sclk_o;
                for (int k = 0; k < 3; k++) begin
                    wait_edge(n);
                    check(n == half, req, n, half);
                    check(sclk_o == !prev_sclk, "R4 sclk alternates", sclk_o, !prev_sclk);
                    prev_sclk = sclk_o;
                end
                stop_and_check_quiet();
            end
        end

        // R6: first coarse strobe latency
        coarse_sel_i = 2'd2;
        fine_code_i  = 2'd0;
        enable_i     = 1'b1;
        wait_coarse(n);
        check(n == 7, "R6 first coarse latency", n, 7);
        stop_and_check_quiet();

        // R7: coarse change mid-count waits for the wrap
        coarse_sel_i = 2'd3;
        fine_code_i  = 2'd0;
        enable_i     = 1'b1;
        wait_coarse(n);
        @(negedge clk);
        coarse_sel_i = 2'd0;
        wait_coarse(n);
        check(n + 1 == 10, "R7 old coarse interval kept", n + 1, 10);
        wait_coarse(n);
        check(n == 2, "R7 new coarse interval", n, 2);
        stop_and_check_quiet();

        // R8: fine change mid-count waits for the wrap
        coarse_sel_i = 2'd0;
        fine_code_i  = 2'd2;
        enable_i     = 1'b1;
        wait_edge(n);
        @(negedge clk);
        fine_code_i = 2'd0;
        wait_edge(n);
        check(n + 1 == 8, "R8 old edge interval kept", n + 1, 8);
        wait_edge(n);
        check(n == 2, "R8 new edge interval", n, 2);
        stop_and_check_quiet();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule